// File: doc/BRIEF.md
# Dual-Format Calendar Time Counter

This block keeps a seven-field calendar: seconds, minutes, hours, day of week, date, month and two-digit year. Each pulse on `tick` advances it by exactly one second, with carries through minutes, hours, days, months and years. A mode input chooses how every field is encoded: straight binary or packed BCD. A second mode input chooses the hour format: 0–23, or 1–12 with a PM flag in bit 7. February gains a 29th day in years divisible by four. When enabled, the daylight-saving jumps are applied on the right Sunday of April and of October.

The counter is double buffered. A running copy always counts. A user copy is what the host reads through `rd_addr`/`rd_data`. While `set_mode` is high, the user copy is frozen and host writes land in it, while the running copy keeps counting. When `set_mode` falls, one of two things happens. If the host wrote anything during the hold, the user copy is loaded into the running copy. If it wrote nothing, the user copy catches up with the running copy. Writes are never back-pressured: each `wr_valid` cycle either lands (hold active) or is dropped (hold inactive), and no ready signal exists.

Field addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Address 7 reads zero.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the user copy reads seconds 00, minutes 00, hours 01, day of week 01, date 01, month 01, year 00.
- R2: With `bin_mode`=0 every field is packed BCD (tens in bits 7:4, units in bits 3:0). Carries follow decimal digits, for example minutes 0x19 with seconds 0x59 become 0x20 and 0x00.
- R3: With `bin_mode`=1 every field is a plain binary count, for example 0x3B seconds roll to 0x00.
- R4: With `hr24_mode`=1 the hour runs 0–23. Hour 23 rolls to 0, and the day of week (1–7, Sunday=1) and date advance; day 7 wraps to 1.
- R5: With `hr24_mode`=0 the hour runs 1–12 with bit 7 = PM. 11 AM becomes 12 PM, 11 PM becomes 12 AM with a day carry, and 12 becomes 1 with PM kept.
- R6: April, June, September and November have 30 days. February has 29 days when year mod 4 is 0 and 28 otherwise. The other months have 31 days.
- R7: December rolls to January with a year carry, and year 99 rolls to 00.
- R8: With `dst_en`=1, on a Sunday with month 4 and date 1–7, the step after 1:59:59 AM gives 3:00:00 AM. Otherwise that step gives 2:00:00.
- R9: With `dst_en`=1, on a Sunday with month 10 and date 25–31, the first step after 1:59:59 AM gives 1:00:00 AM. The second arrival at 1:59:59 that day proceeds to 2:00:00.
- R10: While `set_mode`=1 a `wr_valid` cycle writes `wr_data` to the field at `wr_addr` of the user copy. Bit 7 of the seconds field always reads 0.
- R11: While `set_mode`=0 a `wr_valid` cycle leaves every field unchanged.
- R12: While `set_mode`=1 the user copy does not follow ticks, but the running copy does. If nothing was written, the cycle after `set_mode` falls shows the time including every tick of the hold.
- R13: If the host wrote during the hold, the running copy restarts from the user copy when `set_mode` falls. While `set_mode`=0, each tick makes the user copy equal to the advanced running copy one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second update strobe, one cycle wide |
| set_mode | input | 1 | Hold: freeze the user copy and accept host writes |
| bin_mode | input | 1 | 1 = binary fields, 0 = BCD fields |
| hr24_mode | input | 1 | 1 = 24-hour, 0 = 12-hour with PM bit |
| dst_en | input | 1 | Enable daylight-saving jumps |
| wr_valid | input | 1 | Host write strobe |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Field address of the read |
| rd_data | output | 8 | Field from the user copy, combinational |

## Verification
A wrong carry or a wrong decode shows up in `rd_data` one cycle after the tick that crosses the boundary. An outright wrong digit appears in that cycle, and a field that should have advanced instead shows its old value. A stale one-shot for the October step stays hidden until the repeated hour ends, 3600 ticks later, when the hour comes back as 01 instead of 02. A freeze or hand-over fault shows in the first cycle after `set_mode` falls, as a count that either misses the ticks spent in the hold or discards the host's writes.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int FIELD_AW = 3;
  localparam int NFIELD   = 7;

  typedef logic [7:0] byte_t;
  typedef logic [6:0] num_t;

  typedef struct packed {
    byte_t sec;
    byte_t min;
    byte_t hour;
    byte_t dow;
    byte_t date;
    byte_t mon;
    byte_t year;
  } cal_t;

  localparam cal_t CAL_RESET = '{sec: 8'h00, min: 8'h00, hour: 8'h01, dow: 8'h01,
                                 date: 8'h01, mon: 8'h01, year: 8'h00};

  function automatic num_t field_dec(input byte_t v, input logic bin);
    if (bin) return v[6:0];
    return num_t'(7'(v[7:4]) * 7'd10 + 7'(v[3:0]));
  endfunction

  function automatic byte_t field_enc(input num_t n, input logic bin);
    if (bin) return {1'b0, n};
    return {4'(n / 7'd10), 4'(n % 7'd10)};
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
`timescale 1ns/1ps
module rtc_month_len
  import rtc_cal_pkg::*;
(
  input  num_t mon,
  input  num_t year,
  output num_t last_day
);
  always_comb begin
    case (mon)
      7'd2:                       last_day = (year[1:0] == 2'd0) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    last_day = 7'd30;
      default:                    last_day = 7'd31;
    endcase
  end
endmodule

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
module rtc_cal_step
  import rtc_cal_pkg::*;
(
  input  cal_t cur,
  input  logic bin_mode,
  input  logic hr24_mode,
  input  logic dst_en,
  input  logic fb_done,
  output cal_t nxt,
  output logic fb_fire,
  output logic day_roll
);
  num_t s, m, h12_in, h24, dw, dt, mo, yr, last_day;
  num_t ns, nm, nh, ndw, ndt, nmo, nyr, h12_out;
  logic top_of_hour, spring, fall;

  assign s  = field_dec(cur.sec, bin_mode);
  assign m  = field_dec(cur.min, bin_mode);
  assign dw = field_dec(cur.dow, bin_mode);
  assign dt = field_dec(cur.date, bin_mode);
  assign mo = field_dec(cur.mon, bin_mode);
  assign yr = field_dec(cur.year, bin_mode);
  assign h12_in = field_dec({1'b0, cur.hour[6:0]}, bin_mode);

  // Hour is handled internally as 0..23 whatever the external format
  always_comb begin
    if (hr24_mode) h24 = field_dec(cur.hour, bin_mode);
    else           h24 = ((h12_in >= 7'd12) ? 7'd0 : h12_in) + (cur.hour[7] ? 7'd12 : 7'd0);
  end

  rtc_month_len u_len (.mon(mo), .year(yr), .last_day(last_day));

  assign top_of_hour = (s >= 7'd59) && (m >= 7'd59) && (h24 == 7'd1);
  assign spring = dst_en && top_of_hour && (mo == 7'd4)  && (dw == 7'd1) && (dt <= 7'd7);
  assign fall   = dst_en && top_of_hour && (mo == 7'd10) && (dw == 7'd1) && (dt >= 7'd25) && !fb_done;

  always_comb begin
    ns = s + 7'd1; nm = m; nh = h24;
    ndw = dw; ndt = dt; nmo = mo; nyr = yr;
    day_roll = 1'b0;
    fb_fire  = 1'b0;
    if (s >= 7'd59) begin
      ns = 7'd0;
      nm = m + 7'd1;
      if (m >= 7'd59) begin
        nm = 7'd0;
        if (spring)              nh = 7'd3;
        else if (fall) begin     nh = 7'd1; fb_fire = 1'b1; end
        else if (h24 >= 7'd23) begin nh = 7'd0; day_roll = 1'b1; end
        else                     nh = h24 + 7'd1;
      end
    end
    if (day_roll) begin
      ndw = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
      if (dt >= last_day) begin
        ndt = 7'd1;
        if (mo >= 7'd12) begin
          nmo = 7'd1;
          nyr = (yr >= 7'd99) ? 7'd0 : yr + 7'd1;
        end else begin
          nmo = mo + 7'd1;
        end
      end else begin
        ndt = dt + 7'd1;
      end
    end
  end

  always_comb begin
    h12_out = (nh >= 7'd12) ? nh - 7'd12 : nh;
    if (h12_out == 7'd0) h12_out = 7'd12;
  end

  always_comb begin
    nxt.sec  = field_enc(ns, bin_mode);
    nxt.min  = field_enc(nm, bin_mode);
    nxt.hour = hr24_mode ? field_enc(nh, bin_mode)
                         : {(nh >= 7'd12), field_enc(h12_out, bin_mode)[6:0]};
    nxt.dow  = field_enc(ndw, bin_mode);
    nxt.date = field_enc(ndt, bin_mode);
    nxt.mon  = field_enc(nmo, bin_mode);
    nxt.year = field_enc(nyr, bin_mode);
  end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
  import rtc_cal_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                set_mode,
  input  logic                bin_mode,
  input  logic                hr24_mode,
  input  logic                dst_en,
  input  logic                wr_valid,
  input  logic [FIELD_AW-1:0] wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [FIELD_AW-1:0] rd_addr,
  output logic [7:0]          rd_data
);
  cal_t run_q, usr_q, nxt;
  logic set_q, dirty_q, fb_done_q, fb_fire, day_roll, release_hold;

  assign release_hold = set_q && !set_mode;

  rtc_cal_step u_step (
    .cur(run_q), .bin_mode(bin_mode), .hr24_mode(hr24_mode), .dst_en(dst_en),
    .fb_done(fb_done_q), .nxt(nxt), .fb_fire(fb_fire), .day_roll(day_roll)
  );

  // Running copy and one-shot for the repeated autumn hour
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= CAL_RESET;
      set_q     <= 1'b0;
      dirty_q   <= 1'b0;
      fb_done_q <= 1'b0;
    end else begin
      set_q <= set_mode;
      if (release_hold) begin
        if (dirty_q) begin
          run_q     <= usr_q;
          fb_done_q <= 1'b0;
        end
        dirty_q <= 1'b0;
      end else if (tick) begin
        run_q <= nxt;
        if (fb_fire)       fb_done_q <= 1'b1;
        else if (day_roll) fb_done_q <= 1'b0;
      end
      if (set_mode && wr_valid) dirty_q <= 1'b1;
    end
  end

  // User copy: host-written during hold, mirror of the running copy otherwise
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      usr_q <= CAL_RESET;
    end else if (set_mode) begin
      if (wr_valid) begin
        case (wr_addr)
          3'd0:    usr_q.sec  <= {1'b0, wr_data[6:0]};
          3'd1:    usr_q.min  <= wr_data;
          3'd2:    usr_q.hour <= wr_data;
          3'd3:    usr_q.dow  <= wr_data;
          3'd4:    usr_q.date <= wr_data;
          3'd5:    usr_q.mon  <= wr_data;
          3'd6:    usr_q.year <= wr_data;
          default: ;
        endcase
      end
    end else if (release_hold) begin
      if (!dirty_q) usr_q <= run_q;
    end else if (tick) begin
      usr_q <= nxt;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = usr_q.sec;
      3'd1:    rd_data = usr_q.min;
      3'd2:    rd_data = usr_q.hour;
      3'd3:    rd_data = usr_q.dow;
      3'd4:    rd_data = usr_q.date;
      3'd5:    rd_data = usr_q.mon;
      3'd6:    rd_data = usr_q.year;
      default: rd_data = 8'h00;
    endcase
  end

  p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !wr_valid) |=> $stable(usr_q));

  p_mirror_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode && !release_hold && tick) |=> (usr_q == run_q));

  p_drop_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_mode && !set_q && !tick && wr_valid) |=> $stable(usr_q));

  p_sec_msb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_q.sec[7] == 1'b0));

  p_sec_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !release_hold) |=> !$stable(run_q.sec));

  p_fall_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_done_q && !release_hold && tick && !day_roll) |=> fb_done_q);
endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, set_mode = 1'b0, bin_mode = 1'b0, hr24_mode = 1'b0, dst_en = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar_core dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .set_mode(set_mode), .bin_mode(bin_mode),
    .hr24_mode(hr24_mode), .dst_en(dst_en), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {bin, hr24, dst}, start fields sec..year, expected fields after one tick
  localparam logic [114:0] VEC [15] = '{
    {3'b010, 56'h59592307311299, 56'h00000001010100},
    {3'b110, 56'h3B3B17071F0C63, 56'h00000001010100},
    {3'b000, 56'h59591103150624, 56'h00009203150624},
    {3'b000, 56'h59599103150624, 56'h00001204160624},
    {3'b100, 56'h3B3B8C020A0318, 56'h000081020A0318},
    {3'b010, 56'h59592304280224, 56'h00000005290224},
    {3'b010, 56'h59592304280223, 56'h00000005010323},
    {3'b010, 56'h59592302300425, 56'h00000003010525},
    {3'b010, 56'h59190902100525, 56'h00200902100525},
    {3'b001, 56'h59590101050426, 56'h00000301050426},
    {3'b001, 56'h59590101120426, 56'h00000201120426},
    {3'b000, 56'h59590101050426, 56'h00000201050426},
    {3'b011, 56'h59590101271024, 56'h00000101271024},
    {3'b011, 56'h59590101201024, 56'h00000201201024},
    {3'b110, 56'h3B3B17041D0218, 56'h00000005010318}
  };

  function automatic string vec_tag(input int k);
    case (k)
      0: return "R2 R4 R7";
      1: return "R3 R7";
      2, 3: return "R5";
      4: return "R3 R5";
      5, 6, 7: return "R6";
      8: return "R2";
      9, 10, 11: return "R8";
      12, 13: return "R9";
      default: return "R3 R6";
    endcase
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [2:0] addr, input logic [7:0] exp);
    rd_addr = addr;
    #1;
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s field %0d act=%02h exp=%02h", req, addr, rd_data, exp);
    end
  endtask

  task automatic load_only(input logic [2:0] mode, input logic [55:0] f);
    {bin_mode, hr24_mode, dst_en} = mode;
    tick = 1'b0;
    set_mode = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wr_valid = 1'b1; wr_addr = 3'(i); wr_data = f[55-8*i -: 8];
      cyc();
    end
    wr_valid = 1'b0;
    set_mode = 1'b0;
    cyc();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset contents
    chk("R1", 3'd0, 8'h00); chk("R1", 3'd1, 8'h00); chk("R1", 3'd2, 8'h01);
    chk("R1", 3'd3, 8'h01); chk("R1", 3'd4, 8'h01); chk("R1", 3'd5, 8'h01);
    chk("R1", 3'd6, 8'h00);

    // R11 write outside hold is dropped
    wr_valid = 1'b1; wr_addr = 3'd1; wr_data = 8'h33;
    cyc();
    wr_valid = 1'b0;
    chk("R11", 3'd1, 8'h00);
    chk("R11", 3'd7, 8'h00);

    // R10 write during hold, seconds bit 7 forced low
    set_mode = 1'b1;
    wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 8'hC5;
    cyc();
    wr_valid = 1'b0;
    chk("R10", 3'd0, 8'h45);
    set_mode = 1'b0;
    cyc();

    // Table walk: load, one tick, read all fields
    for (int k = 0; k < 15; k++) begin
      load_only(VEC[k][114:112], VEC[k][111:56]);
      tick = 1'b1; cyc(); tick = 1'b0;
      for (int i = 0; i < 7; i++) chk(vec_tag(k), 3'(i), VEC[k][55-8*i -: 8]);
    end

    // R12 freeze while running copy advances, resume with elapsed time
    load_only(3'b010, 56'h00000501010100);
    tick = 1'b1;
    repeat (3) cyc();
    chk("R13", 3'd0, 8'h03);
    set_mode = 1'b1;
    repeat (5) cyc();
    tick = 1'b0;
    chk("R12", 3'd0, 8'h03);
    set_mode = 1'b0;
    cyc();
    chk("R12", 3'd0, 8'h08);
    tick = 1'b1; cyc(); tick = 1'b0;
    chk("R13", 3'd0, 8'h09);

    // R13 host write during hold wins over elapsed time
    set_mode = 1'b1; tick = 1'b1;
    wr_valid = 1'b1; wr_addr = 3'd1; wr_data = 8'h42;
    cyc();
    wr_valid = 1'b0;
    repeat (4) cyc();
    set_mode = 1'b0; tick = 1'b0;
    cyc();
    chk("R13", 3'd0, 8'h09);
    chk("R13", 3'd1, 8'h42);

    // R9 repeated hour passes 1:59:59 a second time into 2:00:00
    load_only(3'b011, 56'h59590101271024);
    tick = 1'b1; cyc();
    tick = 1'b0;
    chk("R9", 3'd2, 8'h01);
    tick = 1'b1;
    repeat (3600) cyc();
    tick = 1'b0;
    chk("R9", 3'd0, 8'h00);
    chk("R9", 3'd1, 8'h00);
    chk("R9", 3'd2, 8'h02);
    chk("R9", 3'd4, 8'h27);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule